// File: doc/BRIEF.md
# Watermarked Word Queue with Status Flags

This block is a single first-in first-out queue of data words. It is set up by one packed configuration word, which gives the base page of the queue's slice of a shared region, a size code that selects the capacity, and two 3-bit thresholds. The queue has one access point. Asserting `push` stores `push_data` at the tail. Asserting `pop` takes the head word and shows it on `pop_data` in the same cycle.

Four live status flags report how full the queue is. A sticky overflow flag records any push that was refused because the queue was full. A configuration word of zero marks the queue as unused. Writing any configuration word, zero included, empties the queue and clears the overflow flag. The `acc_addr` output gives the word address inside the shared region of the slot that the current access touches.

Top module: `wm_queue`

## Requirements
- R1: After reset, `status` is 0x3 (empty and nearly-empty set), `overflow` is 0, `active` is 0 and `pop_data` is 0.
- R2: The configuration word carries these fields: nearly-full threshold in bits 31:29, nearly-empty threshold in bits 28:26, size code in bits 25:24 and base page in bits 21:14. `active` is 1 exactly when the stored word is nonzero. A configuration write empties the queue and clears `overflow`, and it takes priority over a push or pop in the same cycle.
- R3: The capacity is 16 << size code, giving 16, 32, 64 or 128 words. `status[3]` (full) is set exactly when the fill count equals the capacity.
- R4: Words leave in the order they were accepted. A popped word appears on `pop_data` combinationally, in the cycle `pop` is high.
- R5: A pop from an empty queue returns 0 and changes no state.
- R6: A push into a full queue, without a pop in the same cycle, stores nothing and sets `overflow`. `overflow` stays set until `ovf_clr` is asserted or a configuration write occurs. A new overflow event wins over `ovf_clr` in the same cycle.
- R7: The status bits are: bit 0 empty (count is 0) and bit 1 nearly-empty (count is at or below the nearly-empty threshold).
- R8: `status[2]` (nearly-full) is set when the free space (capacity minus count) is at or below the nearly-full threshold.
- R9: A push and a pop accepted in the same cycle leave the count unchanged. This also holds when the queue is full: the head word leaves and the new word is stored. When the queue is empty, the pop returns 0 and the push is still stored.
- R10: While the stored configuration is zero, pushes are ignored, pops return 0 and `status` stays 0x3.
- R11: `acc_addr` equals base page × 16 plus the write slot index while `push` is high, and plus the read slot index otherwise. Slot indexes start at 0 after a configuration write and wrap at the capacity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load `cfg_wdata` as the configuration |
| cfg_wdata | input | 32 | Packed configuration word |
| push | input | 1 | Push request |
| push_data | input | DATA_W | Word to push |
| pop | input | 1 | Pop request |
| pop_data | output | DATA_W | Popped word, or 0 |
| ovf_clr | input | 1 | Clear the sticky overflow flag |
| status | output | 4 | {full, nearly-full, nearly-empty, empty} |
| overflow | output | 1 | Sticky overflow flag |
| active | output | 1 | Configuration is nonzero |
| acc_addr | output | 12 | Region word address of the current access |

## Verification
A wrong fill count shows on `status` right after the clock edge that produced it. Walking the count through each threshold and the capacity exposes an off-by-one on the following sample. A wrong read pointer shows as a misordered or repeated word on `pop_data` at the very next pop, and it also shows on `acc_addr` before that pop's edge. A wrong overflow decision shows either as a missing sticky flag or as the refused word appearing later in the drained sequence.

// File: rtl/wmq_pkg.sv
package wmq_pkg;
  localparam int CFG_W     = 32;
  localparam int PAGE_W    = 8;
  localparam int PAGE_WORDS = 16;
  localparam int MAX_WORDS = 128;
  localparam int AW        = $clog2(MAX_WORDS);
  localparam int CNT_W     = AW + 1;
  localparam int ADDR_W    = PAGE_W + $clog2(PAGE_WORDS);

  // Field positions are fixed by the configuration word layout.
  typedef struct packed {
    logic [2:0]        nf_wm;   // 31:29
    logic [2:0]        ne_wm;   // 28:26
    logic [1:0]        size;    // 25:24
    logic [1:0]        rsvd;    // 23:22
    logic [PAGE_W-1:0] base;    // 21:14
    logic [13:0]       low;     // 13:0
  } qcfg_t;

  typedef struct packed {
    logic full;
    logic nfull;
    logic nempty;
    logic empty;
  } qstat_t;

  function automatic logic [CNT_W-1:0] cap_of(input logic [1:0] code);
    return CNT_W'(PAGE_WORDS) << code;
  endfunction
endpackage

// File: rtl/wmq_store.sv
module wmq_store #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 128,
  localparam int AW    = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/wmq_ctrl.sv
module wmq_ctrl
  import wmq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             active,
  input  logic [CNT_W-1:0] cap,
  input  logic             push,
  input  logic             pop,
  input  logic             ovf_clr,
  output logic             push_ok,
  output logic             pop_ok,
  output logic [AW-1:0]    wr_ptr,
  output logic [AW-1:0]    rd_ptr,
  output logic [CNT_W-1:0] count,
  output logic             overflow
);
  logic [AW-1:0]    wr_d, rd_d, mask;
  logic [CNT_W-1:0] cnt_d;
  logic             ovf_d, ovf_set, is_full;

  assign mask    = cap[AW-1:0] - AW'(1);
  assign is_full = (count == cap);
  assign pop_ok  = active & pop & (count != '0);
  assign push_ok = active & push & (~is_full | pop_ok);
  assign ovf_set = active & push & is_full & ~pop_ok;

  always_comb begin
    wr_d  = wr_ptr;
    rd_d  = rd_ptr;
    cnt_d = count;
    ovf_d = overflow;
    if (cfg_we) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
      ovf_d = 1'b0;
    end else begin
      if (push_ok) wr_d = (wr_ptr + AW'(1)) & mask;
      if (pop_ok)  rd_d = (rd_ptr + AW'(1)) & mask;
      case ({push_ok, pop_ok})
        2'b10:   cnt_d = count + CNT_W'(1);
        2'b01:   cnt_d = count - CNT_W'(1);
        default: cnt_d = count;
      endcase
      if (ovf_set)      ovf_d = 1'b1;
      else if (ovf_clr) ovf_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      wr_ptr   <= wr_d;
      rd_ptr   <= rd_d;
      count    <= cnt_d;
      overflow <= ovf_d;
    end
  end

  AST_COUNT_LE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> count <= cap); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && is_full && !cfg_we) |=> (count == $past(count)) && overflow); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !ovf_clr && !cfg_we) |=> overflow); // R6
  AST_PUSHPOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop_ok && !cfg_we) |=> count == $past(count)); // R9
  AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && count == '0 && !cfg_we) |=> $stable(rd_ptr) && count == '0); // R5
endmodule

// File: rtl/wmq_flags.sv
module wmq_flags
  import wmq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] cap,
  input  logic [2:0]       ne_wm,
  input  logic [2:0]       nf_wm,
  output qstat_t           stat
);
  logic [CNT_W-1:0] free_w;

  assign free_w = cap - count;

  always_comb begin
    stat.empty  = (count == '0);
    stat.nempty = (count <= CNT_W'(ne_wm));
    stat.nfull  = (free_w <= CNT_W'(nf_wm));
    stat.full   = (count == cap);
  end

  AST_FULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat.full && stat.empty)); // R7
endmodule

// File: rtl/wm_queue.sv
module wm_queue
  import wmq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  input  logic              ovf_clr,
  output logic [3:0]        status,
  output logic              overflow,
  output logic              active,
  output logic [ADDR_W-1:0] acc_addr
);
  qcfg_t            cfg_q, cfg_d;
  qstat_t           stat;
  logic [CNT_W-1:0] cap, count;
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [DATA_W-1:0] rdata;
  logic             push_ok, pop_ok;

  assign cfg_d = cfg_we ? qcfg_t'(cfg_wdata) : cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign active = |cfg_q;
  assign cap    = cap_of(cfg_q.size);

  wmq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .active(active), .cap(cap),
    .push(push), .pop(pop), .ovf_clr(ovf_clr), .push_ok(push_ok),
    .pop_ok(pop_ok), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .count(count),
    .overflow(overflow)
  );

  wmq_store #(.DATA_W(DATA_W), .WORDS(MAX_WORDS)) u_store (
    .clk(clk), .we(push_ok), .waddr(wr_ptr), .wdata(push_data),
    .raddr(rd_ptr), .rdata(rdata)
  );

  wmq_flags u_flags (
    .clk(clk), .rst_n(rst_n), .count(count), .cap(cap),
    .ne_wm(cfg_q.ne_wm), .nf_wm(cfg_q.nf_wm), .stat(stat)
  );

  assign status   = stat;
  assign pop_data = pop_ok ? rdata : '0;
  assign acc_addr = {cfg_q.base, {($clog2(PAGE_WORDS)){1'b0}}}
                    + ADDR_W'(push ? wr_ptr : rd_ptr);

  AST_EMPTY_POP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && status[0]) |-> pop_data == '0); // R5
  AST_IDLE_WHEN_UNUSED: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (status == 4'h3 && pop_data == '0)); // R10
  AST_CFG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (status[0] && !overflow)); // R2
endmodule

// File: tb/wm_queue_bench.sv
module wm_queue_bench;
  localparam int DW = 32;
  localparam logic [31:0] CFG16  = (32'd3 << 29) | (32'd2 << 26) | (32'd0 << 24) | (32'd5 << 14);
  localparam logic [31:0] CFG128 = (32'd3 << 29) | (32'd2 << 26) | (32'd3 << 24) | (32'd5 << 14);

  typedef struct packed {
    logic        pu;
    logic        po;
    logic [31:0] d;
    logic [31:0] xpop;
    logic [3:0]  xstat;
    logic        xovf;
  } vec_t;

  // Capacity 16, nearly-empty threshold 2, nearly-full threshold 3, starting empty.
  localparam vec_t VECS [10] = '{
    '{1'b0, 1'b1, 32'h0,  32'h0,  4'h3, 1'b0},  // pop empty -> 0 (R5)
    '{1'b1, 1'b0, 32'hA1, 32'h0,  4'h2, 1'b0},  // count 1 (R7)
    '{1'b1, 1'b0, 32'hA2, 32'h0,  4'h2, 1'b0},  // count 2 at threshold (R7)
    '{1'b1, 1'b0, 32'hA3, 32'h0,  4'h0, 1'b0},  // count 3
    '{1'b1, 1'b1, 32'hA4, 32'hA1, 4'h0, 1'b0},  // push+pop keeps 3 (R9)
    '{1'b0, 1'b1, 32'h0,  32'hA2, 4'h2, 1'b0},  // order (R4)
    '{1'b0, 1'b1, 32'h0,  32'hA3, 4'h2, 1'b0},
    '{1'b0, 1'b1, 32'h0,  32'hA4, 4'h3, 1'b0},
    '{1'b1, 1'b1, 32'hA5, 32'h0,  4'h2, 1'b0},  // push+pop on empty (R9)
    '{1'b0, 1'b1, 32'h0,  32'hA5, 4'h3, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we, push, pop, ovf_clr;
  logic [31:0]   cfg_wdata;
  logic [DW-1:0] push_data, pop_data, last_pop;
  logic [3:0]    status;
  logic          overflow, active;
  logic [11:0]   acc_addr, last_addr;
  int            nchk = 0;
  int            nfail = 0;
  bit            done = 1'b0;

  always #4 clk = ~clk;

  wm_queue #(.DATA_W(DW)) u_wm_queue (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .push(push), .push_data(push_data), .pop(pop), .pop_data(pop_data),
    .ovf_clr(ovf_clr), .status(status), .overflow(overflow),
    .active(active), .acc_addr(acc_addr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic pu, input logic po, input logic [31:0] d, input logic clr);
    @(negedge clk);
    push = pu; pop = po; push_data = d; ovf_clr = clr;
    #1;
    last_pop  = pop_data;
    last_addr = acc_addr;
    @(posedge clk);
    #2;
    push = 1'b0; pop = 1'b0; ovf_clr = 1'b0;
  endtask

  task automatic cfg(input logic [31:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = w;
    @(posedge clk);
    #2;
    cfg_we = 1'b0;
  endtask

  function automatic logic [3:0] xst(input int cnt, input int capv, input int ne, input int nf);
    return {cnt == capv, (capv - cnt) <= nf, cnt <= ne, cnt == 0};
  endfunction

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; push = 1'b0; pop = 1'b0;
    ovf_clr = 1'b0; push_data = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 status", 32'(status), 32'h3);
    chk("R1 overflow", 32'(overflow), 32'h0);
    chk("R1 active", 32'(active), 32'h0);
    chk("R1 pop_data", pop_data, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    // Unused queue ignores traffic
    step(1'b1, 1'b0, 32'h55, 1'b0);
    chk("R10 status after push", 32'(status), 32'h3);
    step(1'b0, 1'b1, 32'h0, 1'b0);
    chk("R10 pop returns 0", last_pop, 32'h0);
    chk("R10 no overflow", 32'(overflow), 32'h0);

    cfg(CFG16);
    chk("R2 active", 32'(active), 32'h1);
    #1;
    chk("R11 idle address", 32'(acc_addr), 32'd80);

    foreach (VECS[i]) begin
      step(VECS[i].pu, VECS[i].po, VECS[i].d, 1'b0);
      if (VECS[i].po) chk($sformatf("R4 vec%0d pop", i), last_pop, VECS[i].xpop);
      chk($sformatf("R7 vec%0d status", i), 32'(status), 32'(VECS[i].xstat));
      chk($sformatf("R6 vec%0d overflow", i), 32'(overflow), 32'(VECS[i].xovf));
    end

    // Fill a 16-word queue, checking thresholds on the way
    cfg(CFG16);
    for (int k = 0; k < 16; k++) begin
      step(1'b1, 1'b0, 32'd100 + 32'(k), 1'b0);
      if (k == 11 || k == 12 || k == 15)
        chk($sformatf("R8 fill %0d status", k + 1), 32'(status), 32'(xst(k + 1, 16, 2, 3)));
    end
    chk("R3 full at 16", 32'(status), 32'hC);
    step(1'b1, 1'b1, 32'd200, 1'b0);
    chk("R9 pop while full", last_pop, 32'd100);
    chk("R9 still full", 32'(status), 32'hC);
    step(1'b1, 1'b0, 32'd300, 1'b1);
    chk("R6 overflow set beats clear", 32'(overflow), 32'h1);
    chk("R6 still full", 32'(status), 32'hC);
    for (int k = 0; k < 16; k++) begin
      step(1'b0, 1'b1, 32'h0, 1'b0);
      if (k == 0) chk("R11 pop address", 32'(last_addr), 32'd81);
      chk($sformatf("R4 drain %0d", k), last_pop, (k == 15) ? 32'd200 : 32'd101 + 32'(k));
    end
    chk("R6 overflow sticky", 32'(overflow), 32'h1);
    chk("R7 empty after drain", 32'(status), 32'h3);
    step(1'b0, 1'b0, 32'h0, 1'b1);
    chk("R6 overflow cleared", 32'(overflow), 32'h0);

    // Largest size code
    cfg(CFG128);
    for (int k = 0; k < 128; k++) begin
      step(1'b1, 1'b0, 32'(k), 1'b0);
      if (k == 15) chk("R3 not full at 16 of 128", 32'(status), 32'h0);
      if (k == 124) chk("R8 nearly full at 125", 32'(status), 32'h4);
      if (k == 126) chk("R3 not full at 127", 32'(status[3]), 32'h0);
    end
    chk("R3 full at 128", 32'(status), 32'hC);
    cfg(CFG128);
    chk("R2 config write empties", 32'(status), 32'h3);

    cfg(32'h0);
    chk("R10 released inactive", 32'(active), 32'h0);
    chk("R10 released status", 32'(status), 32'h3);
    step(1'b1, 1'b1, 32'h77, 1'b0);
    chk("R10 pop gives 0 when unused", last_pop, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule